// File: doc/BRIEF.md
# Vector Signed Rounding Average Unit

This block executes one vector instruction: the rounded average of four signed 32-bit lanes. A 32-bit instruction word arrives with a valid strobe and is decoded in the cycle it is presented. If it matches the encoding, the two source vectors are read from an internal file of 32 registers of 128 bits in the following cycle. The per-lane average is then written back to the destination register at the end of that cycle. A word that does not match raises an illegal-instruction pulse instead and writes nothing.

Each lane sum is formed one bit wider than the lane, so the result never wraps and never saturates. Halves round toward positive infinity. Lane 0 is the most-significant word of a register. A load port fills registers. A combinational debug port reads any register at any time.

Top module: `vavg_unit`

## Requirements
- R1: A word is accepted as the average instruction only when bits [31:26] equal 4 and bits [10:0] equal 1410. For such a word the destination number is bits [25:21], source A is bits [20:16] and source B is bits [15:11].
- R2: A valid matching word sampled at clock edge N makes `done` high for exactly the cycle between edges N and N+1. The destination register is written at edge N+1.
- R3: Lane i of a register occupies bits [127-32i : 96-32i], so lane 0 is the most-significant word. Each result lane equals floor((A + B + 1) / 2), computed over signed integers without overflow. The result always lies between the two source lanes.
- R4: Rounding is half-up toward positive infinity. The average of -1 and 0 is 0, the average of 1 and 2 is 2, and the average of -3 and -2 is -2.
- R5: Extreme lanes give exact results. 0x7FFFFFFF with 0x7FFFFFFF gives 0x7FFFFFFF, 0x80000000 with 0x80000000 gives 0x80000000, and 0x7FFFFFFF with 0x80000000 gives 0. Equal source lanes give that same value.
- R6: The destination may equal either source or both. The result is computed from the register values held before the write.
- R7: A valid word that does not match R1 writes no register. It raises `illegal` for exactly the next cycle, and `done` stays low.
- R8: A high `ld_en` at a clock edge writes `ld_data` into register `ld_addr`. `dbg_data` always shows register `dbg_addr` without a clock delay.
- R9: While reset is low, all 32 registers read zero, and `done` and `illegal` are low.
- R10: When an instruction write and a load target the same register at the same edge, the instruction result is kept.
- R11: Without a valid strobe, `done` and `illegal` stay low in the next cycle and no register changes except through the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn_word | input | 32 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_addr | input | 5 | Register number to load |
| ld_data | input | 128 | Value to load |
| dbg_addr | input | 5 | Register number to observe |
| dbg_data | output | 128 | Contents of register `dbg_addr` |
| done | output | 1 | The destination register is written at the end of this cycle |
| illegal | output | 1 | The previous valid word did not decode |

## Verification
A corrupted execute stage shows at `done` or `illegal` one cycle after the offending word. It may pulse when it should not, stay silent, or raise both. A wrong lane sum, a misplaced lane or a stale alias read becomes visible on `dbg_data` as soon as the destination is selected after the write edge. The bench keeps its own copy of all 32 registers and compares the observed register and both pulses at every clock. An error therefore shows within one or two cycles of its cause rather than at the end of a run.

// File: rtl/vavg_pkg.sv
package vavg_pkg;
  parameter int LANE_W  = 32;
  parameter int LANES   = 4;
  parameter int VEC_W   = LANE_W * LANES;
  parameter int REG_N   = 32;
  parameter int ADDR_W  = $clog2(REG_N);
  parameter logic [5:0]  PRI_OP = 6'd4;
  parameter logic [10:0] EXT_OP = 11'd1410;

  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] ra;
    logic [4:0] rb;
  } vavg_fields_t;
endpackage

// File: rtl/vavg_decode.sv
module vavg_decode
  import vavg_pkg::*;
#(
  parameter logic [5:0]  PRI = PRI_OP,
  parameter logic [10:0] EXT = EXT_OP
) (
  input  logic [31:0]  word,
  output vavg_fields_t fields,
  output logic         match
);
  // Bit 0 of the format is the MSB of the word.
  always_comb begin
    fields.rd = word[25:21];
    fields.ra = word[20:16];
    fields.rb = word[15:11];
    match     = (word[31:26] == PRI) && (word[10:0] == EXT);
  end
endmodule

// File: rtl/vavg_lanes.sv
module vavg_lanes #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0] va,
  input  logic [VEC_W-1:0] vb,
  output logic [VEC_W-1:0] vr
);
  function automatic logic [LANE_W-1:0] lane_avg(input logic [LANE_W-1:0] a,
                                                 input logic [LANE_W-1:0] b);
    logic [LANE_W:0] s;
    s = {a[LANE_W-1], a} + {b[LANE_W-1], b} + (LANE_W+1)'(1);
    return s[LANE_W:1];
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = VEC_W - 1 - i * LANE_W;
    assign vr[HI -: LANE_W] = lane_avg(va[HI -: LANE_W], vb[HI -: LANE_W]);
  end
endmodule

// File: rtl/vavg_regfile.sv
module vavg_regfile #(
  parameter int VEC_W = 128,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ra_addr,
  output logic [VEC_W-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [VEC_W-1:0] rb_data,
  input  logic [AW-1:0]    dbg_addr,
  output logic [VEC_W-1:0] dbg_data,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [VEC_W-1:0] ld_data,
  input  logic             ex_en,
  input  logic [AW-1:0]    ex_addr,
  input  logic [VEC_W-1:0] ex_data
);
  logic [VEC_W-1:0] mem [DEPTH];

  assign ra_data  = mem[ra_addr];
  assign rb_data  = mem[rb_addr];
  assign dbg_data = mem[dbg_addr];

  // The execute write is applied after the load, so it wins a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ld_en) mem[ld_addr] <= ld_data;
      if (ex_en) mem[ex_addr] <= ex_data;
    end
  end

  // R10: the execute result survives a same-edge load to the same register
  a_r10_exec_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ex_en |=> mem[$past(ex_addr)] == $past(ex_data));

  // R8: a lone load lands in the addressed register
  a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(ex_en && ex_addr == ld_addr)) |=> mem[$past(ld_addr)] == $past(ld_data));
endmodule

// File: rtl/vavg_unit.sv
module vavg_unit
  import vavg_pkg::*;
#(
  parameter int LW  = LANE_W,
  parameter int NL  = LANES,
  parameter int NR  = REG_N,
  localparam int VW = LW * NL,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [31:0]   insn_word,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [VW-1:0] ld_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [VW-1:0] dbg_data,
  output logic          done,
  output logic          illegal
);
  vavg_fields_t dec_fields;
  logic         dec_match;
  vavg_fields_t ex_fields;
  logic         ex_vld;
  logic         ill_q;
  logic [VW-1:0] src_a, src_b, res;

  vavg_decode u_dec (
    .word   (insn_word),
    .fields (dec_fields),
    .match  (dec_match)
  );

  // Single execute stage: decode registered, operands read in next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld    <= 1'b0;
      ill_q     <= 1'b0;
      ex_fields <= '0;
    end else begin
      ex_vld <= insn_valid && dec_match;
      ill_q  <= insn_valid && !dec_match;
      if (insn_valid && dec_match) ex_fields <= dec_fields;
    end
  end

  vavg_regfile #(.VEC_W(VW), .DEPTH(NR)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_addr  (ex_fields.ra[AW-1:0]),
    .ra_data  (src_a),
    .rb_addr  (ex_fields.rb[AW-1:0]),
    .rb_data  (src_b),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .ex_en    (ex_vld),
    .ex_addr  (ex_fields.rd[AW-1:0]),
    .ex_data  (res)
  );

  vavg_lanes #(.LANE_W(LW), .LANES(NL)) u_lanes (
    .va (src_a),
    .vb (src_b),
    .vr (res)
  );

  assign done    = ex_vld;
  assign illegal = ill_q;

  // R2: a valid matching word is followed by a done pulse
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && dec_match) |=> (done && !illegal));

  // R7: a valid non-matching word is followed by an illegal pulse, no write
  a_r7_illegal_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !dec_match) |=> (illegal && !done));

  // R11: idle input leaves both pulses low
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!done && !illegal));

  for (genvar i = 0; i < NL; i++) begin : g_chk
    localparam int HI = VW - 1 - i * LW;
    // R3: the average never leaves the interval spanned by its sources
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (($signed(res[HI -: LW]) >= $signed(src_a[HI -: LW])) ||
                ($signed(res[HI -: LW]) >= $signed(src_b[HI -: LW]))) &&
               (($signed(res[HI -: LW]) <= $signed(src_a[HI -: LW])) ||
                ($signed(res[HI -: LW]) <= $signed(src_b[HI -: LW]))));
    // R5: equal lanes reproduce themselves exactly
    a_r5_equal_inputs: assert property (@(posedge clk) disable iff (!rst_n)
      (done && src_a[HI -: LW] == src_b[HI -: LW]) |-> res[HI -: LW] == src_a[HI -: LW]);
  end
endmodule

// File: tb/vavg_unit_bench.sv
`timescale 1ns/1ps
module vavg_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn_word = '0;
  logic         ld_en = 1'b0;
  logic [4:0]   ld_addr = '0;
  logic [127:0] ld_data = '0;
  logic [4:0]   dbg_addr = '0;
  logic [127:0] dbg_data;
  logic         done, illegal;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vavg_unit u_vavg_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .done(done), .illegal(illegal)
  );

  // ---------------- behavioural reference ----------------
  logic [127:0] model [32];
  bit       pend_ok = 0, pend_bad = 0;
  bit [4:0] pend_d, pend_a, pend_b;

  function automatic bit ours(input logic [31:0] w);
    return (w[31:26] == 6'd4) && (w[10:0] == 11'd1410);
  endfunction

  function automatic logic [31:0] mk(input int d, input int a, input int b);
    logic [31:0] w;
    w = 32'h1000_0582;
    w[25:21] = 5'(d); w[20:16] = 5'(a); w[15:11] = 5'(b);
    return w;
  endfunction

  function automatic logic [127:0] ref_avg(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      longint sx, sy, t;
      sx = longint'($signed(x[127-32*k -: 32]));
      sy = longint'($signed(y[127-32*k -: 32]));
      t  = sx + sy + 1;
      t  = t >>> 1;
      r[127-32*k -: 32] = t[31:0];
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) model[k] = '0;
      pend_ok = 0; pend_bad = 0;
    end else begin
      logic [127:0] r;
      r = '0;
      if (pend_ok) r = ref_avg(model[pend_a], model[pend_b]);
      if (ld_en) model[ld_addr] = ld_data;
      if (pend_ok) model[pend_d] = r;
      pend_ok  = insn_valid && ours(insn_word);
      pend_bad = insn_valid && !ours(insn_word);
      pend_d = insn_word[25:21]; pend_a = insn_word[20:16]; pend_b = insn_word[15:11];
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done == pend_ok, "R2 done", 128'(done), 128'(pend_ok));
      check(illegal == pend_bad, "R7 illegal", 128'(illegal), 128'(pend_bad));
      check(dbg_data == model[dbg_addr], "R3 register contents", dbg_data, model[dbg_addr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic load(input int a, input logic [127:0] d);
    @(negedge clk); ld_en = 1; ld_addr = 5'(a); ld_data = d;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic run(input logic [31:0] w);
    @(negedge clk); insn_valid = 1; insn_word = w;
    @(negedge clk); insn_valid = 0;
    @(negedge clk);
  endtask

  task automatic peek(input int a, input logic [127:0] exp, input string req);
    dbg_addr = 5'(a); #1;
    check(dbg_data == exp, req, dbg_data, exp);
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R9: reset contents and outputs
    for (int k = 0; k < 32; k++) peek(k, '0, "R9 reset register");
    check(!done && !illegal, "R9 reset pulses", 128'({done, illegal}), '0);
    rst_n = 1;

    // R4, R5: rounding and extremes, r3 = avg(r1, r2)
    load(1, {32'hFFFF_FFFF, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000});
    load(2, {32'h0,         32'd2, 32'h7FFF_FFFF, 32'h8000_0000});
    run(mk(3, 1, 2));
    peek(3, {32'h0, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000}, "R4 R5 rounding and extremes");
    load(5, {32'h7FFF_FFFF, 32'hFFFF_FFFD, 32'h7FFF_FFFF, 32'h0});
    load(6, {32'h8000_0000, 32'hFFFF_FFFE, 32'h8000_0000, 32'h0});
    run(mk(4, 5, 6));
    peek(4, {32'h0, 32'hFFFF_FFFE, 32'h0, 32'h0}, "R5 R4 mixed extremes and -3,-2");

    // R3: lane 0 is the most-significant word
    load(7, {32'd2, 32'd0, 32'd0, 32'd0});
    run(mk(8, 7, 9));
    peek(8, {32'd1, 96'd0}, "R3 lane order");

    // R6: aliasing destination with a source
    run(mk(1, 1, 2));
    peek(1, {32'h0, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000}, "R6 alias dest=A");
    peek(2, {32'h0, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000}, "R6 source B unchanged");
    run(mk(5, 5, 5));
    peek(5, {32'h7FFF_FFFF, 32'hFFFF_FFFD, 32'h7FFF_FFFF, 32'h0}, "R6 alias all three");

    // R1 field positions with high register numbers
    load(30, {4{32'd10}});
    load(29, {4{32'd20}});
    run(mk(31, 30, 29));
    peek(31, {4{32'd15}}, "R1 field positions");

    // R7: non-matching words write nothing
    run(32'h1400_0582 | 32'h0060_0000);   // wrong primary code, rd=3
    peek(3, {32'h0, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000}, "R7 no write on bad primary");
    run(32'h1000_0583 | 32'h0060_0000);   // wrong extended code, rd=3
    peek(3, {32'h0, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000}, "R7 no write on bad extended");

    // R10: load and execute write collide on register 12
    load(10, {4{32'd4}});
    load(11, {4{32'd6}});
    @(negedge clk); insn_valid = 1; insn_word = mk(12, 10, 11);
    @(negedge clk); insn_valid = 0; ld_en = 1; ld_addr = 5'd12; ld_data = {4{32'hDEAD_BEEF}};
    @(negedge clk); ld_en = 0;
    peek(12, {4{32'd5}}, "R10 execute wins collision");

    // R11: idle cycles change nothing
    repeat (4) @(negedge clk);
    peek(12, {4{32'd5}}, "R11 idle keeps state");
    check(!done && !illegal, "R11 idle pulses", 128'({done, illegal}), '0);

    // R8 and random mix, reference-compared every clock
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      ld_en = ($urandom_range(0, 3) == 0);
      ld_addr = 5'($urandom);
      ld_data = {pick32(), pick32(), pick32(), pick32()};
      insn_valid = ($urandom_range(0, 2) != 0);
      insn_word = ($urandom_range(0, 7) == 0) ? 32'($urandom)
                : mk($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
      dbg_addr = 5'($urandom);
    end
    @(negedge clk); insn_valid = 0; ld_en = 0;
    load(20, {32'h1234_5678, 32'h0, 32'h1, 32'h2});
    peek(20, {32'h1234_5678, 32'h0, 32'h1, 32'h2}, "R8 load visible on debug port");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule